// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block sits between an interrupt source layer and one processor. It holds at most one pending interrupt, identified by a source number and an 8-bit priority, and drives a single interrupt line to the processor. The source layer offers interrupts on a valid/ready channel. The block answers each offer: it either latches the offer or sends it back with a reject pulse. Whenever it displaces or drops a pending entry, it rejects that entry too. It also forwards end-of-interrupt notices, and it pulses a resend request when the source layer should offer any held-back interrupts again.

The processor side carries one command per cycle. The commands set the current processor priority, write the inter-processor-interrupt (IPI) priority, accept the pending interrupt, signal end-of-interrupt, or poll. A numerically lower priority is more favoured. 0xFF is the least favoured priority, and it also means "nothing pending". An IPI is shown as a reserved source number (parameter `IPI_SRC`). That IPI entry competes for the single slot like any other interrupt.

Back-pressure: `offer_ready` is low in any cycle where `cmd_valid` is high, because the processor command wins that cycle. An offer is taken only when `offer_valid` and `offer_ready` are both high. Processor commands are never stalled.

Top module: `intr_present_unit`

## Requirements
- R1: After reset, a poll returns an acknowledge word of 0 and an IPI priority of 0xFF, `irq_out` is low, and the pending priority is 0xFF.
- R2: The acknowledge word holds the processor priority in bits 31:24 and the pending source in bits 23:0. A zero source field means the slot is empty, and `irq_out` is high exactly while the source field is non-zero.
- R3: A taken offer is rejected when its priority is greater than or equal to the processor priority, or when the slot holds an entry whose priority is less than or equal to the offer's. A reject is a one-cycle `rej_pulse` with the offered number on `src_bus`, and the slot is left unchanged.
- R4: Any other taken offer is latched and raises `irq_out`. Any entry it displaces is rejected in the same cycle.
- R5: Accept (opcode 2) returns the acknowledge word as it stood before the command. It then loads the processor priority from the pending priority, empties the slot, sets the pending priority to 0xFF and lowers `irq_out`.
- R6: End-of-interrupt (opcode 3) loads the processor priority from bits 31:24 of `cmd_data` and pulses `eoi_pulse` with bits 23:0 on `src_bus`. If the slot is empty, it also performs a resend.
- R7: Setting the processor priority (opcode 0, value in `cmd_data[7:0]`) to a more favoured value empties the slot when the held entry's priority is greater than or equal to the new value. That entry is then rejected and `irq_out` falls. If the slot is empty, nothing else happens.
- R8: Setting the processor priority to an equal or less favoured value while the slot is empty performs a resend. A resend pulses `resend_pulse` and, when the IPI priority is more favoured than the processor priority, first runs the IPI check.
- R9: Writing the IPI priority (opcode 1, value in `cmd_data[7:0]`) stores it. If it is more favoured than the processor priority and the held entry is not at least as favoured, `IPI_SRC` is latched with the IPI priority, `irq_out` rises, and any displaced entry is rejected.
- R10: Poll (opcode 4) returns the acknowledge word and the IPI priority and changes no state. Opcodes 5 to 7 have no effect.
- R11: `offer_ready` is low whenever `cmd_valid` is high, and an offer presented in such a cycle leaves the slot unchanged.
- R12: A reject never carries `IPI_SRC`. A pending IPI that is displaced or dropped is discarded silently and comes back through the IPI check.
- R13: `rsp_valid` is high in the cycle after each accept or poll, and only then. The pulses and the state take effect in the cycle after the command or offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source layer offers an interrupt |
| offer_ready | output | 1 | Offer is taken this cycle |
| offer_src | input | SRC_W | Offered source number |
| offer_prio | input | PRIO_W | Offered priority |
| cmd_valid | input | 1 | Processor command present |
| cmd_op | input | 3 | Command opcode (0 set priority, 1 IPI priority, 2 accept, 3 EOI, 4 poll) |
| cmd_data | input | SRC_W+PRIO_W | Command operand |
| rsp_valid | output | 1 | Response for accept or poll |
| rsp_word | output | SRC_W+PRIO_W | Acknowledge word returned |
| rsp_ipi | output | PRIO_W | IPI priority returned |
| rej_pulse | output | 1 | Reject notice to the source layer |
| eoi_pulse | output | 1 | End-of-interrupt notice to the source layer |
| resend_pulse | output | 1 | Resend request to the source layer |
| src_bus | output | SRC_W | Source number for a reject or an EOI |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The hardest state to reach is an IPI that sits in the slot and is then displaced, first by an offer and then by a more favoured IPI write. This needs an IPI priority that is stored while it is not yet effective. The stimulus writes the IPI priority while the processor priority is strict, then relaxes the processor priority so that the resend path injects the IPI. It then offers a better source to check the silent displacement. Finally it raises the IPI priority further, so that the offered source is rejected in favour of the IPI.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_SET_CPPR = 3'd0,
    OP_SET_IPI  = 3'd1,
    OP_ACCEPT   = 3'd2,
    OP_EOI      = 3'd3,
    OP_POLL     = 3'd4
  } cpu_op_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_OFFER, EV_CPPR, EV_IPI, EV_ACCEPT, EV_EOI, EV_POLL
  } ipc_ev_e;
endpackage

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
  import ipc_pkg::*;
(
  input  logic       offer_valid,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  output logic       offer_ready,
  output ipc_ev_e    ev
);
  assign offer_ready = !cmd_valid;

  always_comb begin
    ev = EV_NONE;
    if (cmd_valid) begin
      case (cmd_op)
        OP_SET_CPPR: ev = EV_CPPR;
        OP_SET_IPI:  ev = EV_IPI;
        OP_ACCEPT:   ev = EV_ACCEPT;
        OP_EOI:      ev = EV_EOI;
        OP_POLL:     ev = EV_POLL;
        default:     ev = EV_NONE;
      endcase
    end else if (offer_valid) begin
      ev = EV_OFFER;
    end
  end
endmodule

// File: rtl/ipc_next_state.sv
module ipc_next_state
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input  ipc_ev_e           ev,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [PRIO_W-1:0] cppr_q,
  input  logic [SRC_W-1:0]  xisr_q,
  input  logic [PRIO_W-1:0] pend_q,
  input  logic [PRIO_W-1:0] mfrr_q,
  output logic [PRIO_W-1:0] cppr_d,
  output logic [SRC_W-1:0]  xisr_d,
  output logic [PRIO_W-1:0] pend_d,
  output logic [PRIO_W-1:0] mfrr_d,
  output logic              rej_fire,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_fire,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend_fire
);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] low_pr, top_pr;
  logic              busy, held_ipi, do_ipi, do_resend;

  assign low_pr   = cmd_data[PRIO_W-1:0];
  assign top_pr   = cmd_data[WORD_W-1 -: PRIO_W];
  assign busy     = (xisr_q != '0);
  assign held_ipi = (xisr_q == IPI_NUM);

  always_comb begin
    cppr_d = cppr_q;  xisr_d = xisr_q;  pend_d = pend_q;  mfrr_d = mfrr_q;
    rej_fire = 1'b0;  rej_src = '0;
    eoi_fire = 1'b0;  eoi_src = '0;
    resend_fire = 1'b0;
    do_ipi = 1'b0;    do_resend = 1'b0;
    case (ev)
      EV_OFFER: begin
        if (offer_prio >= cppr_q || (busy && pend_q <= offer_prio)) begin
          rej_fire = 1'b1;
          rej_src  = offer_src;
        end else begin
          if (busy && !held_ipi) begin
            rej_fire = 1'b1;
            rej_src  = xisr_q;
          end
          xisr_d = offer_src;
          pend_d = offer_prio;
        end
      end
      EV_CPPR: begin
        cppr_d = low_pr;
        if (low_pr < cppr_q) begin
          if (busy && low_pr <= pend_q) begin
            xisr_d = '0;
            pend_d = PRIO_NONE;
            if (!held_ipi) begin
              rej_fire = 1'b1;
              rej_src  = xisr_q;
            end
          end
        end else if (!busy) begin
          do_resend = 1'b1;
        end
      end
      EV_IPI: begin
        mfrr_d = low_pr;
        if (low_pr < cppr_q) do_ipi = 1'b1;
      end
      EV_ACCEPT: begin
        cppr_d = pend_q;
        xisr_d = '0;
        pend_d = PRIO_NONE;
      end
      EV_EOI: begin
        cppr_d   = top_pr;
        eoi_fire = 1'b1;
        eoi_src  = cmd_data[SRC_W-1:0];
        if (!busy) do_resend = 1'b1;
      end
      default: ;
    endcase

    if (do_resend) begin
      resend_fire = 1'b1;
      if (mfrr_d < cppr_d) do_ipi = 1'b1;
    end

    if (do_ipi && !(xisr_d != '0 && pend_d <= mfrr_d)) begin
      if (xisr_d != '0 && xisr_d != IPI_NUM) begin
        rej_fire = 1'b1;
        rej_src  = xisr_d;
      end
      xisr_d = IPI_NUM;
      pend_d = mfrr_d;
    end
  end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_valid,
  output logic              offer_ready,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic [PRIO_W-1:0] rsp_ipi,
  output logic              rej_pulse,
  output logic              eoi_pulse,
  output logic              resend_pulse,
  output logic [SRC_W-1:0]  src_bus,
  output logic              irq_out
);
  ipc_ev_e           ev;
  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q, cppr_d, pend_d, mfrr_d;
  logic [SRC_W-1:0]  xisr_q, xisr_d, rej_src, eoi_src;
  logic              rej_fire, eoi_fire, resend_fire;

  ipc_arbiter u_arb (
    .offer_valid (offer_valid),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .offer_ready (offer_ready),
    .ev          (ev)
  );

  ipc_next_state #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_ns (
    .ev          (ev),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .cmd_data    (cmd_data),
    .cppr_q      (cppr_q),
    .xisr_q      (xisr_q),
    .pend_q      (pend_q),
    .mfrr_q      (mfrr_q),
    .cppr_d      (cppr_d),
    .xisr_d      (xisr_d),
    .pend_d      (pend_d),
    .mfrr_d      (mfrr_d),
    .rej_fire    (rej_fire),
    .rej_src     (rej_src),
    .eoi_fire    (eoi_fire),
    .eoi_src     (eoi_src),
    .resend_fire (resend_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q       <= '0;
      xisr_q       <= '0;
      pend_q       <= '1;
      mfrr_q       <= '1;
      irq_out      <= 1'b0;
      rej_pulse    <= 1'b0;
      eoi_pulse    <= 1'b0;
      resend_pulse <= 1'b0;
      src_bus      <= '0;
      rsp_valid    <= 1'b0;
      rsp_word     <= '0;
      rsp_ipi      <= '0;
    end else begin
      cppr_q       <= cppr_d;
      xisr_q       <= xisr_d;
      pend_q       <= pend_d;
      mfrr_q       <= mfrr_d;
      irq_out      <= (xisr_d != '0);
      rej_pulse    <= rej_fire;
      eoi_pulse    <= eoi_fire;
      resend_pulse <= resend_fire;
      src_bus      <= rej_fire ? rej_src : (eoi_fire ? eoi_src : '0);
      rsp_valid    <= (ev == EV_ACCEPT) || (ev == EV_POLL);
      if ((ev == EV_ACCEPT) || (ev == EV_POLL)) begin
        rsp_word <= {cppr_q, xisr_q};
        rsp_ipi  <= mfrr_q;
      end
    end
  end
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              offer_valid,
  input logic              offer_ready,
  input logic [SRC_W-1:0]  offer_src,
  input logic [PRIO_W-1:0] offer_prio,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [WORD_W-1:0] cmd_data,
  input logic              rsp_valid,
  input logic              rej_pulse,
  input logic              eoi_pulse,
  input logic [SRC_W-1:0]  src_bus,
  input logic              irq_out,
  input logic [PRIO_W-1:0] cppr_q,
  input logic [SRC_W-1:0]  xisr_q,
  input logic [PRIO_W-1:0] pend_q
);
  // R2
  line_tracks_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (xisr_q != '0));
  // R2
  empty_slot_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xisr_q == '0) |-> (pend_q == '1));
  // R3
  low_offer_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && offer_ready && offer_prio >= cppr_q)
      |=> (rej_pulse && src_bus == $past(offer_src)));
  // R5
  accept_drops_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> (rsp_valid && !irq_out));
  // R6
  eoi_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3)
      |=> (eoi_pulse && !rej_pulse && src_bus == $past(cmd_data[SRC_W-1:0])));
  // R11
  cmd_blocks_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !offer_ready);
  // R12
  no_ipi_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |-> (src_bus != SRC_W'(IPI_SRC)));
endmodule

bind intr_present_unit ipc_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .offer_valid (offer_valid),
  .offer_ready (offer_ready),
  .offer_src   (offer_src),
  .offer_prio  (offer_prio),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_data    (cmd_data),
  .rsp_valid   (rsp_valid),
  .rej_pulse   (rej_pulse),
  .eoi_pulse   (eoi_pulse),
  .src_bus     (src_bus),
  .irq_out     (irq_out),
  .cppr_q      (cppr_q),
  .xisr_q      (xisr_q),
  .pend_q      (pend_q)
);

// File: tb/tb_intr_present_unit.sv
module tb_intr_present_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        offer_valid = 1'b0, offer_ready;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        rsp_valid, rej_pulse, eoi_pulse, resend_pulse, irq_out;
  logic [31:0] rsp_word;
  logic [7:0]  rsp_ipi;
  logic [23:0] src_bus;

  int n_chk = 0, n_fail = 0;
  logic        g_rej, g_eoi, g_res, g_rspv, g_irq, g_ready;
  logic [23:0] g_bus;
  logic [31:0] g_word;
  logic [7:0]  g_ipi;

  intr_present_unit dut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic capture();
    g_rej = rej_pulse; g_eoi = eoi_pulse; g_res = resend_pulse; g_bus = src_bus;
    g_rspv = rsp_valid; g_word = rsp_word; g_ipi = rsp_ipi; g_irq = irq_out;
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    capture();
    cmd_valid = 1'b0;
  endtask

  task automatic do_offer(input logic [23:0] s, input logic [7:0] p);
    @(negedge clk);
    offer_valid = 1'b1; offer_src = s; offer_prio = p;
    #1 g_ready = offer_ready;
    @(negedge clk);
    capture();
    offer_valid = 1'b0;
  endtask

  task automatic poll_expect(input string tag, input logic [31:0] w, input logic [7:0] ipi);
    do_cmd(3'd4, 32'h0);
    check(g_rspv, {tag, " rsp_valid"}, 32'(g_rspv), 1);
    check(g_word == w, {tag, " word"}, g_word, w);
    check(g_ipi == ipi, {tag, " ipi"}, 32'(g_ipi), 32'(ipi));
    check(g_irq == (w[23:0] != 0), {tag, " irq"}, 32'(g_irq), 32'(w[23:0] != 0));
  endtask

  task automatic t_reset();  // R1 R13
    poll_expect("R1 reset", 32'h0, 8'hFF);
    @(negedge clk);
    check(!rsp_valid, "R13 rsp one cycle", 32'(rsp_valid), 0);
  endtask

  task automatic t_strict_then_relax();
    do_offer(24'h40, 8'h10);  // R3 prio >= cppr 0
    check(g_ready && g_rej && g_bus == 24'h40, "R3 reject vs cppr", {8'h0, g_bus}, 32'h40);
    do_cmd(3'd0, 32'hFF);     // R8 empty, less favoured
    check(g_res && !g_rej, "R8 resend", 32'(g_res), 1);
    poll_expect("R3 slot empty", 32'hFF000000, 8'hFF);
  endtask

  task automatic t_offers();
    do_offer(24'h10, 8'd5);   // R4
    check(!g_rej && g_irq, "R4 latch", 32'(g_irq), 1);
    poll_expect("R2 format", 32'hFF000010, 8'hFF);
    do_offer(24'h11, 8'd7);   // R3 pending better
    check(g_rej && g_bus == 24'h11, "R3 pending better", {8'h0, g_bus}, 32'h11);
    do_offer(24'h12, 8'd5);   // R3 equal
    check(g_rej && g_bus == 24'h12, "R3 equal prio", {8'h0, g_bus}, 32'h12);
    do_offer(24'h13, 8'd3);   // R4 displacement
    check(g_rej && g_bus == 24'h10, "R4 displaced reject", {8'h0, g_bus}, 32'h10);
    poll_expect("R4 new entry", 32'hFF000013, 8'hFF);
  endtask

  task automatic t_accept_eoi();
    do_cmd(3'd2, 32'h0);      // R5
    check(g_rspv && g_word == 32'hFF000013, "R5 accept word", g_word, 32'hFF000013);
    check(!g_irq, "R5 line low", 32'(g_irq), 0);
    poll_expect("R5 after accept", 32'h03000000, 8'hFF);
    do_cmd(3'd3, 32'hFF000013);  // R6
    check(g_eoi && g_bus == 24'h13 && g_res, "R6 eoi+resend", {8'h0, g_bus}, 32'h13);
    poll_expect("R6 cppr loaded", 32'hFF000000, 8'hFF);
  endtask

  task automatic t_cppr_tighten();
    do_offer(24'h20, 8'd8);
    do_cmd(3'd0, 32'h08);     // R7
    check(g_rej && g_bus == 24'h20 && !g_irq, "R7 cleared", {8'h0, g_bus}, 32'h20);
    poll_expect("R7 state", 32'h08000000, 8'hFF);
    do_cmd(3'd0, 32'h04);     // R7 empty, no action
    check(!g_rej && !g_res, "R7 empty quiet", {30'h0, g_rej, g_res}, 0);
  endtask

  task automatic t_ipi();
    do_cmd(3'd1, 32'h06);     // R9 not effective yet
    check(!g_irq && !g_rej, "R9 stored only", 32'(g_irq), 0);
    poll_expect("R9 stored", 32'h04000000, 8'h06);
    do_cmd(3'd0, 32'hFF);     // R8 resend injects IPI
    check(g_res && !g_rej && g_irq, "R8 resend ipi", {30'h0, g_res, g_irq}, 3);
    poll_expect("R8 ipi pending", 32'hFF000002, 8'h06);
    do_offer(24'h30, 8'd2);   // R12 silent displacement
    check(!g_rej && g_irq, "R12 no ipi reject", 32'(g_rej), 0);
    poll_expect("R12 offer holds", 32'hFF000030, 8'h06);
    do_cmd(3'd1, 32'h01);     // R9 ipi displaces
    check(g_rej && g_bus == 24'h30, "R9 displace", {8'h0, g_bus}, 32'h30);
    poll_expect("R9 ipi wins", 32'hFF000002, 8'h01);
    do_cmd(3'd2, 32'h0);
    check(g_word == 32'hFF000002, "R5 ipi accept", g_word, 32'hFF000002);
    do_cmd(3'd1, 32'hFF);
    do_cmd(3'd3, 32'hFF000002);
    check(g_eoi && g_res && !g_irq && g_bus == 24'h2, "R6 ipi eoi", {8'h0, g_bus}, 32'h2);
    poll_expect("R10 final", 32'hFF000000, 8'hFF);
  endtask

  task automatic t_handshake();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_data = '0;
    offer_valid = 1'b1; offer_src = 24'h55; offer_prio = 8'd1;
    #1 g_ready = offer_ready;
    check(!g_ready, "R11 ready low", 32'(g_ready), 0);
    @(negedge clk);
    capture();
    cmd_valid = 1'b0; offer_valid = 1'b0;
    check(!g_irq && !g_rej, "R11 offer ignored", 32'(g_irq), 0);
    do_cmd(3'd7, 32'hFFFFFFFF);  // R10 unused opcode
    check(!g_rspv && !g_eoi && !g_res, "R10 no effect op", 32'(g_rspv), 0);
    poll_expect("R10 unchanged", 32'hFF000000, 8'hFF);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_strict_then_relax();
    t_offers();
    t_accept_eoi();
    t_cppr_tighten();
    t_ipi();
    t_handshake();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule